// File: doc/BRIEF.md
# PCM Voice Time-Slot Port

This block is a serial PCM voice port that moves one 8-bit companded sample per frame in each direction. A frame-sync pulse marks the start of a frame. The port then works in one of two 8-bit B-channel slots. In the selected slot it shifts a transmit byte out on a serial output that has an enable, and it shifts a received byte in from a serial input. The block runs on a single system clock. The bit clock reaches it as two one-cycle strobes, one for the rising bit edge and one for the falling bit edge.

A host programs the port over a simple parallel write bus with an address and a combinational read port. A control byte sets five things: whether the port is enabled, which slot it uses, whether the decoder receives the line byte or a host-written byte, whether the encoder byte or a host-written byte goes out on the line, and the level of an inverted general-purpose latch pin. The control byte also holds a clock-choice bit. The block only stores that bit and presents it on a pin. The line byte captured in each frame can be read back through the receive address.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset the control byte reads 0, which means the port is disabled, slot B1 is selected, the main clock is chosen and no override is set. In this state ser_oe is 0, dec_valid is 0 and latch_out is 1.
- R2: Control bit 5 is the latch data. latch_out is the inverse of that bit, so writing 1 drives the pin low and writing 0 drives it high.
- R3: The host bus uses these addresses: address 0 is the control byte (read/write), address 1 is the receive register and address 2 is the transmit register. The control byte has clock choice at bit 0, slot select at bit 1, enable at bit 2, transmit override at bit 3, receive override at bit 4 and latch data at bit 5. Reading address 0 returns the control byte.
- R4: A bit_rise strobe with fsync high starts bit position 0. Each later bit_rise advances the position by one, and the position holds at 16 until the next fsync. Slot B1 (slot select 0) covers positions 0 to 7 and slot B2 (slot select 1) covers positions 8 to 15.
- R5: While the port is enabled, ser_oe is 1 exactly during the 8 positions of the selected slot. ser_out sends the transmit byte most significant bit first, and each bit changes only on a bit_rise.
- R6: When transmit override is clear, the transmit byte is the enc_byte input.
- R7: ser_in is sampled on each bit_fall inside the selected slot, most significant bit first. When the port is enabled, dec_valid pulses for one cycle after the eighth sample, and dec_byte carries the byte.
- R8: When receive override is set, dec_byte at the dec_valid pulse equals the receive register written at address 1, and the line data has no effect on it.
- R9: Reading address 1 returns the byte last received on the line. This happens every frame, whatever the enable and override settings are.
- R10: When transmit override is set, the byte written at address 2 is sent in place of enc_byte. Address 2 is write-only and reads 0.
- R11: The transmit byte is captured at the rising strobe that starts the slot. A write to address 2 during the slot therefore changes only the next frame.
- R12: When the port is disabled, ser_oe stays 0 and no dec_valid pulse occurs.
- R13: aux_clk_sel follows control bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_rise | input | 1 | One-cycle strobe at each rising bit-clock edge |
| bit_fall | input | 1 | One-cycle strobe at each falling bit-clock edge |
| fsync | input | 1 | Frame sync, sampled with bit_rise |
| ser_in | input | 1 | Serial receive data |
| ser_out | output | 1 | Serial transmit data |
| ser_oe | output | 1 | Output enable for ser_out; 0 means high impedance |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr |
| enc_byte | input | 8 | Encoder sample to transmit |
| dec_byte | output | 8 | Sample delivered to the decoder side |
| dec_valid | output | 1 | One-cycle strobe marking a new dec_byte |
| latch_out | output | 1 | Inverted latch pin |
| aux_clk_sel | output | 1 | Stored clock-choice bit |

## Verification
The hardest case to reach is a host write that lands in the middle of the active slot. It must leave the byte already on the line unchanged and take effect only in the next frame. The bench drives the transmit-register write on the same strobe as a chosen bit inside the slot, then compares two consecutive frames. Randomized frames mix both slots, every override combination and random line data, with random noise on ser_in outside the slot. Each random frame checks the serialized byte, where the enable window falls, how many valid strobes occur, and the readback.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
    localparam int CTRL_W = 6;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_RX   = 2'd1;
    localparam logic [1:0] ADDR_TX   = 2'd2;

    // packed so that the field order matches the host-visible bit positions
    typedef struct packed {
        logic latch_data;  // bit 5
        logic rx_ovr;      // bit 4
        logic tx_ovr;      // bit 3
        logic enable;      // bit 2
        logic slot_sel;    // bit 1
        logic clk_choice;  // bit 0
    } ctrl_t;
endpackage

// File: rtl/pcm_ctrl_regs.sv
module pcm_ctrl_regs
    import pcm_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] line_byte,
    output logic [DATA_W-1:0] host_rdata,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] rx_reg,
    output logic [DATA_W-1:0] tx_reg
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] rx_reg;
        logic [DATA_W-1:0] tx_reg;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (host_we) begin
            case (host_addr)
                ADDR_CTRL: r_d.ctrl   = ctrl_t'(host_wdata[CTRL_W-1:0]);
                ADDR_RX:   r_d.rx_reg = host_wdata;
                ADDR_TX:   r_d.tx_reg = host_wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (host_addr)
            ADDR_CTRL: host_rdata = {{(DATA_W-CTRL_W){1'b0}}, r_q.ctrl};
            ADDR_RX:   host_rdata = line_byte;
            default:   host_rdata = '0;
        endcase
    end

    assign ctrl   = r_q.ctrl;
    assign rx_reg = r_q.rx_reg;
    assign tx_reg = r_q.tx_reg;

    // R3: a control write is visible on the next cycle
    assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        host_we && host_addr == ADDR_CTRL |=> ctrl == ctrl_t'($past(host_wdata[CTRL_W-1:0])));
endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer #(
    parameter int SLOT_W = 8,
    localparam int NSLOT = 2,
    localparam int IDLE  = NSLOT * SLOT_W,
    localparam int POS_W = $clog2(IDLE + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_rise,
    input  logic fsync,
    input  logic slot_sel,
    output logic slot_load,
    output logic slot_shift,
    output logic in_slot,
    output logic last_bit
);
    typedef struct packed {
        logic [POS_W-1:0] pos;
    } tim_t;

    tim_t t_d, t_q;
    logic [POS_W-1:0] base, rel_q, rel_d;
    logic             next_in;

    always_comb begin
        t_d = t_q;
        if (bit_rise) begin
            if (fsync)                          t_d.pos = '0;
            else if (t_q.pos != POS_W'(IDLE))   t_d.pos = t_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q.pos <= POS_W'(IDLE);
        else        t_q <= t_d;
    end

    always_comb begin
        base     = slot_sel ? POS_W'(SLOT_W) : '0;
        rel_q    = t_q.pos - base;
        rel_d    = t_d.pos - base;
        in_slot  = (t_q.pos >= base) && (rel_q < POS_W'(SLOT_W));
        next_in  = (t_d.pos >= base) && (rel_d < POS_W'(SLOT_W));
        last_bit = in_slot && (rel_q == POS_W'(SLOT_W - 1));
        slot_load  = bit_rise && (t_d.pos == base);
        slot_shift = bit_rise && next_in && !slot_load;
    end

    // R4: position never passes the idle value
    assert_pos_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.pos <= POS_W'(IDLE));
    // R4: position moves only on a rising strobe
    assert_pos_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_rise |=> $stable(t_q.pos));
endmodule

// File: rtl/pcm_shift_unit.sv
module pcm_shift_unit #(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_load,
    input  logic              slot_shift,
    input  logic              bit_fall,
    input  logic              in_slot,
    input  logic              last_bit,
    input  logic              enable,
    input  logic              tx_ovr,
    input  logic              rx_ovr,
    input  logic [SLOT_W-1:0] enc_byte,
    input  logic [SLOT_W-1:0] tx_reg,
    input  logic [SLOT_W-1:0] rx_reg,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              ser_oe,
    output logic [SLOT_W-1:0] line_byte,
    output logic [SLOT_W-1:0] dec_byte,
    output logic              dec_valid
);
    typedef struct packed {
        logic [SLOT_W-1:0] tx_sh;
        logic [SLOT_W-1:0] rx_sh;
        logic [SLOT_W-1:0] line;
        logic [SLOT_W-1:0] dec;
        logic              dec_v;
    } sh_t;

    sh_t s_d, s_q;
    logic [SLOT_W-1:0] rx_next;

    always_comb begin
        s_d       = s_q;
        s_d.dec_v = 1'b0;
        rx_next   = {s_q.rx_sh[SLOT_W-2:0], ser_in};
        if (slot_load)       s_d.tx_sh = tx_ovr ? tx_reg : enc_byte;
        else if (slot_shift) s_d.tx_sh = {s_q.tx_sh[SLOT_W-2:0], 1'b0};
        if (bit_fall && in_slot) begin
            s_d.rx_sh = rx_next;
            if (last_bit) begin
                s_d.line = rx_next;
                if (enable) begin
                    s_d.dec_v = 1'b1;
                    s_d.dec   = rx_ovr ? rx_reg : rx_next;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ser_out   = s_q.tx_sh[SLOT_W-1];
    assign ser_oe    = enable && in_slot;
    assign line_byte = s_q.line;
    assign dec_byte  = s_q.dec;
    assign dec_valid = s_q.dec_v;

    // R7: the decoder strobe lasts one cycle
    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);
    // R5, R11: serial output changes only right after a rising strobe
    assert_out_on_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(slot_load || slot_shift) |-> $stable(ser_out));
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
    import pcm_port_pkg::*;
#(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_rise,
    input  logic              bit_fall,
    input  logic              fsync,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              ser_oe,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [SLOT_W-1:0] host_wdata,
    output logic [SLOT_W-1:0] host_rdata,
    input  logic [SLOT_W-1:0] enc_byte,
    output logic [SLOT_W-1:0] dec_byte,
    output logic              dec_valid,
    output logic              latch_out,
    output logic              aux_clk_sel
);
    ctrl_t             ctrl;
    logic [SLOT_W-1:0] rx_reg, tx_reg, line_byte;
    logic              slot_load, slot_shift, in_slot, last_bit;

    pcm_ctrl_regs #(.DATA_W(SLOT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .line_byte(line_byte), .host_rdata(host_rdata),
        .ctrl(ctrl), .rx_reg(rx_reg), .tx_reg(tx_reg)
    );

    pcm_frame_timer #(.SLOT_W(SLOT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .fsync(fsync),
        .slot_sel(ctrl.slot_sel), .slot_load(slot_load), .slot_shift(slot_shift),
        .in_slot(in_slot), .last_bit(last_bit)
    );

    pcm_shift_unit #(.SLOT_W(SLOT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .slot_load(slot_load), .slot_shift(slot_shift),
        .bit_fall(bit_fall), .in_slot(in_slot), .last_bit(last_bit),
        .enable(ctrl.enable), .tx_ovr(ctrl.tx_ovr), .rx_ovr(ctrl.rx_ovr),
        .enc_byte(enc_byte), .tx_reg(tx_reg), .rx_reg(rx_reg), .ser_in(ser_in),
        .ser_out(ser_out), .ser_oe(ser_oe), .line_byte(line_byte),
        .dec_byte(dec_byte), .dec_valid(dec_valid)
    );

    assign latch_out   = ~ctrl.latch_data;
    assign aux_clk_sel = ctrl.clk_choice;

    // R2: a control write sets the pin to the inverse of bit 5
    assert_latch_inverse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_we && host_addr == ADDR_CTRL |=> latch_out == !$past(host_wdata[5]));
    // R8: with receive override the decoder gets the host byte
    assert_rx_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && $past(ctrl.rx_ovr) |-> dec_byte == $past(rx_reg));
    // R12: a disabled port never strobes the decoder
    assert_no_valid_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(ctrl.enable));
endmodule

// File: tb/sim_pcm_slot_port.sv
module sim_pcm_slot_port;
    logic       clk = 0, rst_n = 0, bit_rise = 0, bit_fall = 0, fsync = 0, ser_in = 0;
    logic       host_we = 0;
    logic [1:0] host_addr = 0;
    logic [7:0] host_wdata = 0, enc_byte = 0;
    logic       ser_out, ser_oe, dec_valid, latch_out, aux_clk_sel;
    logic [7:0] host_rdata, dec_byte;

    int checks = 0, errors = 0;
    // bench model of the host-visible state
    logic m_en = 0, m_sel = 0, m_txo = 0, m_rxo = 0, m_lat = 0, m_ck = 0;
    logic [7:0] m_tx = 0, m_rx = 0;
    // frame results
    logic [7:0] f_tx, f_dec;
    int         f_oe_in, f_oe_out, f_nv;

    pcm_slot_port u0 (
        .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .bit_fall(bit_fall), .fsync(fsync),
        .ser_in(ser_in), .ser_out(ser_out), .ser_oe(ser_oe), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .enc_byte(enc_byte), .dec_byte(dec_byte), .dec_valid(dec_valid),
        .latch_out(latch_out), .aux_clk_sel(aux_clk_sel)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog all-R actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic [7:0] exp_tx();
        return m_txo ? m_tx : enc_byte;
    endfunction

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 0;
        if (a == 2'd1) m_rx = d;
        if (a == 2'd2) m_tx = d;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic set_ctrl(input logic en, sel, txo, rxo, lat, ck);
        m_en = en; m_sel = sel; m_txo = txo; m_rxo = rxo; m_lat = lat; m_ck = ck;
        host_write(2'd0, {2'b00, lat, rxo, txo, en, sel, ck});
    endtask

    task automatic poll();
        if (dec_valid) begin f_nv++; f_dec = dec_byte; end
    endtask

    // one 18-bit frame; optional transmit-register write on the rise of bit wr_bit
    task automatic run_frame(input logic [7:0] line, input int wr_bit, input logic [7:0] wr_data);
        int base = m_sel ? 8 : 0;
        f_tx = 0; f_dec = 0; f_oe_in = 0; f_oe_out = 0; f_nv = 0;
        for (int b = 0; b < 18; b++) begin
            bit in_s = (b >= base) && (b < base + 8);
            @(negedge clk);
            poll();
            bit_rise = 1; fsync = (b == 0);
            ser_in = in_s ? line[7 - (b - base)] : 1'($urandom);
            if (b == wr_bit) begin host_we = 1; host_addr = 2'd2; host_wdata = wr_data; end
            @(negedge clk);
            poll();
            bit_rise = 0; fsync = 0; host_we = 0;
            if (in_s) f_tx[7 - (b - base)] = ser_out;
            if (ser_oe) begin if (in_s) f_oe_in++; else f_oe_out++; end
            bit_fall = 1;
            @(negedge clk);
            poll();
            bit_fall = 0;
            @(negedge clk);
            poll();
        end
        if (wr_bit >= 0) m_tx = wr_data;
    endtask

    // full check of one frame against the model
    task automatic check_frame(input logic [7:0] line);
        logic [7:0] etx, rd;
        etx = exp_tx();
        run_frame(line, -1, 8'h00);
        if (m_en) begin
            chk(f_oe_in == 8 && f_oe_out == 0, "R5 oe window", f_oe_in + 100 * f_oe_out, 8);
            chk(f_tx == etx, m_txo ? "R10 tx override byte" : "R6 encoder byte", f_tx, etx);
            chk(f_nv == 1, "R7 one valid strobe", f_nv, 1);
            chk(f_dec == (m_rxo ? m_rx : line), m_rxo ? "R8 rx override byte" : "R7 line byte",
                f_dec, m_rxo ? m_rx : line);
        end else begin
            chk(f_oe_in == 0 && f_oe_out == 0, "R12 oe while disabled", f_oe_in + f_oe_out, 0);
            chk(f_nv == 0, "R12 valid while disabled", f_nv, 0);
        end
        host_read(2'd1, rd);
        chk(rd == line, "R9 line readback", rd, line);
    endtask

    initial begin
        logic [7:0] rd, l;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(ser_oe == 0, "R1 ser_oe", ser_oe, 0);
        chk(dec_valid == 0, "R1 dec_valid", dec_valid, 0);
        chk(latch_out == 1, "R1 latch_out", latch_out, 1);
        chk(aux_clk_sel == 0, "R1 aux_clk_sel", aux_clk_sel, 0);
        host_read(2'd0, rd);
        chk(rd == 8'h00, "R1 control reads 0", rd, 0);
        check_frame(8'h96);  // disabled after reset: R12 and R9

        // R2 / R13 / R3 directed
        set_ctrl(0, 0, 0, 0, 1, 1);
        @(negedge clk);
        chk(latch_out == 0, "R2 latch written 1", latch_out, 0);
        chk(aux_clk_sel == 1, "R13 clock choice", aux_clk_sel, 1);
        host_read(2'd0, rd);
        chk(rd == 8'h21, "R3 control readback", rd, 8'h21);
        set_ctrl(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk(latch_out == 1, "R2 latch written 0", latch_out, 1);

        // R10 write-only transmit register
        host_write(2'd2, 8'hC3);
        host_read(2'd2, rd);
        chk(rd == 8'h00, "R10 tx register reads 0", rd, 0);

        // R4/R5/R6 directed: B1 then B2 with encoder data
        enc_byte = 8'h81;
        set_ctrl(1, 0, 0, 0, 0, 0);
        check_frame(8'h01);
        set_ctrl(1, 1, 0, 0, 0, 0);
        check_frame(8'h80);

        // R8 override ignores line data
        host_write(2'd1, 8'h5A);
        set_ctrl(1, 1, 0, 1, 0, 0);
        check_frame(8'hFF);

        // R11 mid-slot write lands in the next frame (B1 and B2)
        for (int s = 0; s < 2; s++) begin
            host_write(2'd2, 8'hA5);
            set_ctrl(1, s[0], 1, 0, 0, 0);
            run_frame(8'h00, (s == 0) ? 3 : 12, 8'h3C);
            chk(f_tx == 8'hA5, "R11 same frame keeps old byte", f_tx, 8'hA5);
            run_frame(8'h00, -1, 8'h00);
            chk(f_tx == 8'h3C, "R11 next frame uses new byte", f_tx, 8'h3C);
        end

        // random frames
        for (int i = 0; i < 40; i++) begin
            enc_byte = 8'($urandom);
            host_write(2'd1, 8'($urandom));
            host_write(2'd2, 8'($urandom));
            set_ctrl((i % 5) != 4 ? 1'b1 : 1'b0, 1'($urandom), 1'($urandom),
                     1'($urandom), 1'($urandom), 1'($urandom));
            @(negedge clk);
            chk(latch_out == !m_lat, "R2 random latch", latch_out, !m_lat);
            chk(aux_clk_sel == m_ck, "R13 random clock choice", aux_clk_sel, m_ck);
            l = 8'($urandom);
            check_frame(l);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
    end
endmodule